// File: doc/BRIEF.md
# Serial Field Transfer Engine

The engine moves a field of characters from a source range (operand 1) to a destination range (operand 2) inside one shared character memory, one character at a time. Each range is given as two addresses. The lower address is the most significant location and the higher address is the least significant location. A start pulse latches both ranges, a direction bit and a clear option. The engine then drives the memory's read and write ports until the move is finished. It ends with a one-cycle done pulse.

Copying runs in one of two directions:
- **Ascending** begins at the least significant ends of both ranges and moves toward lower addresses.
- **Descending** begins at the most significant ends and moves toward higher addresses.

If the destination is longer than the source, the destination locations left over are written with the space code. This padding continues in the direction of the copy. If the source is longer, copying stops once the destination is full. With the clear option set, the source locations are blanked after copying and padding. Only the source locations that fall outside the destination range are blanked.

Every character is read and then written before the next character is read. When the two ranges overlap, the result therefore depends on the direction. Moving data toward higher addresses needs ascending mode. Moving it toward lower addresses needs descending mode. The opposite pairing repeats characters that were already moved.

Top module: `field_xfer`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `rdEn` and `wrEn` are low until a start is accepted.
- R2: A `start` seen while idle is accepted. `busy` is high from the next cycle through the final cycle of the move. `done` is high in exactly that final cycle, which has no memory access, and `busy` is low in the cycle after it.
- R3: Each copied character uses two cycles. In the first, `rdEn` is high with the source address. In the second, `wrEn` is high with the destination address, and `wrData` equals the `rdData` returned for that read. The memory has a read latency of one cycle.
- R4: In ascending mode (`descend`=0), the first character read is at `src1Lsl` and the first written is at `dst2Lsl`. Each later character is one address lower for both ranges.
- R5: In descending mode (`descend`=1), the first character read is at `src1Msl` and the first written is at `dst2Msl`. Each later character is one address higher for both ranges.
- R6: The number of characters copied is the smaller of the two range lengths, where length = LSL − MSL + 1.
- R7: In ascending mode, destination locations below the copied data, down to `dst2Msl`, are then written with the space code 6'b000000, one per cycle in descending address order.
- R8: In descending mode, destination locations above the copied data, up to `dst2Lsl`, are then written with the space code, one per cycle in ascending address order.
- R9: With `clearSrc`=1, after padding the engine walks every source location once, one per cycle, in the direction of the move. It writes the space code only to locations outside [`dst2Msl`, `dst2Lsl`]. Covered locations get a cycle with no write.
- R10: Overlapping ranges are copied exactly when source MSL < destination MSL with ascending mode, or source MSL > destination MSL with descending mode. In the opposite pairing, each read sees the characters already written, so earlier characters repeat.
- R11: A `start` or a change of the range inputs while `busy` is high has no effect on the move in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a move (accepted when idle) |
| src1Msl | input | ADDR_W | Source most significant (lowest) address |
| src1Lsl | input | ADDR_W | Source least significant (highest) address |
| dst2Msl | input | ADDR_W | Destination most significant address |
| dst2Lsl | input | ADDR_W | Destination least significant address |
| descend | input | 1 | 1 = descending order, 0 = ascending order |
| clearSrc | input | 1 | Blank non-covered source locations after the move |
| busy | output | 1 | Move in progress |
| done | output | 1 | Final cycle of a move |
| rdEn | output | 1 | Memory read request |
| rdAddr | output | ADDR_W | Memory read address |
| rdData | input | CHAR_W | Read data, valid one cycle after `rdEn` |
| wrEn | output | 1 | Memory write strobe |
| wrAddr | output | ADDR_W | Memory write address |
| wrData | output | CHAR_W | Memory write data |

## Verification
Two of the block's functions can coincide in one write cycle:
- When the destination is longer than the source, the write of the last copied character is also the cycle that hands over to padding.
- When the clear option is set, the write of the last pad or copy character hands over to the clear walk.

The bench provokes these handovers with ranges of unequal length, including length-one ranges, with the option both on and off. It compares every cycle's read and write strobes, addresses and data against a behavioural model that replays the same serial order on its own copy of memory. Overlap cases in both pairings are judged twice: by that per-cycle comparison, and by hand-computed final memory contents.

// File: rtl/field_xfer_pkg.sv
package field_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_PAD,
    ST_CLEAR,
    ST_FIN
  } xfer_state_t;

  typedef struct packed {
    logic load;
    logic rdEn;
    logic wrCopy;
    logic wrPad;
    logic wrClr;
    logic padInit;
    logic clrInit;
  } xfer_strb_t;

endpackage

// File: rtl/field_xfer_dp.sv
module field_xfer_dp
  import field_xfer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  xfer_strb_t        strb,
  input  logic [ADDR_W-1:0] src1MslIn,
  input  logic [ADDR_W-1:0] src1LslIn,
  input  logic [ADDR_W-1:0] dst2MslIn,
  input  logic [ADDR_W-1:0] dst2LslIn,
  input  logic              descIn,
  input  logic              clearIn,
  input  logic [CHAR_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CHAR_W-1:0] wrData,
  output logic              cntLast,
  output logic              padNeeded,
  output logic              clearOn
);

  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CHAR_W-1:0] SPACE = '0;

  logic [ADDR_W-1:0] op1Msl, op1Lsl, op2Msl, op2Lsl;
  logic              desc, clearOpt;
  logic [ADDR_W-1:0] srcPtr, dstPtr;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  len1, len2, len1In, len2In, minIn;
  logic [ADDR_W-1:0] step;
  logic              covered;

  // Lengths of the latched ranges and of the ranges at the inputs
  always_comb begin
    len1   = {1'b0, op1Lsl} - {1'b0, op1Msl} + 1'b1;
    len2   = {1'b0, op2Lsl} - {1'b0, op2Msl} + 1'b1;
    len1In = {1'b0, src1LslIn} - {1'b0, src1MslIn} + 1'b1;
    len2In = {1'b0, dst2LslIn} - {1'b0, dst2MslIn} + 1'b1;
    minIn  = (len1In < len2In) ? len1In : len2In;
    step   = desc ? {{(ADDR_W-1){1'b0}}, 1'b1} : {ADDR_W{1'b1}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op1Msl   <= '0;
      op1Lsl   <= '0;
      op2Msl   <= '0;
      op2Lsl   <= '0;
      desc     <= 1'b0;
      clearOpt <= 1'b0;
      srcPtr   <= '0;
      dstPtr   <= '0;
      cnt      <= '0;
    end else if (strb.load) begin
      op1Msl   <= src1MslIn;
      op1Lsl   <= src1LslIn;
      op2Msl   <= dst2MslIn;
      op2Lsl   <= dst2LslIn;
      desc     <= descIn;
      clearOpt <= clearIn;
      srcPtr   <= descIn ? src1MslIn : src1LslIn;
      dstPtr   <= descIn ? dst2MslIn : dst2LslIn;
      cnt      <= minIn;
    end else begin
      if (strb.wrCopy) begin
        srcPtr <= srcPtr + step;
        dstPtr <= dstPtr + step;
      end
      if (strb.wrPad) dstPtr <= dstPtr + step;
      if (strb.wrClr) srcPtr <= srcPtr + step;
      if (strb.clrInit) srcPtr <= desc ? op1Msl : op1Lsl;
      if (strb.padInit)
        cnt <= len2 - len1;
      else if (strb.clrInit)
        cnt <= len1;
      else if (strb.wrCopy || strb.wrPad || strb.wrClr)
        cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    covered   = (srcPtr >= op2Msl) && (srcPtr <= op2Lsl);
    rdAddr    = srcPtr;
    wrEn      = strb.wrCopy | strb.wrPad | (strb.wrClr & ~covered);
    wrAddr    = strb.wrClr ? srcPtr : dstPtr;
    wrData    = strb.wrCopy ? rdData : SPACE;
    cntLast   = (cnt == {{(CNT_W-1){1'b0}}, 1'b1});
    padNeeded = (len2 > len1);
    clearOn   = clearOpt;
  end

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> wrEn);

  // R9
  clear_in_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrClr && wrEn) |-> (wrAddr >= op1Msl && wrAddr <= op1Lsl));

  // R11
  ranges_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn || strb.wrCopy || strb.wrPad || strb.wrClr) |=>
      ($stable(op1Msl) && $stable(op1Lsl) && $stable(op2Msl) && $stable(op2Lsl) && $stable(desc)));

endmodule

// File: rtl/field_xfer_ctrl.sv
module field_xfer_ctrl
  import field_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cntLast,
  input  logic       padNeeded,
  input  logic       clearOn,
  output xfer_strb_t strb,
  output logic       busy,
  output logic       done
);

  xfer_state_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.load = 1'b1;
        nextState = ST_READ;
      end
      ST_READ: begin
        strb.rdEn = 1'b1;
        nextState = ST_WRITE;
      end
      ST_WRITE: begin
        strb.wrCopy = 1'b1;
        if (!cntLast) nextState = ST_READ;
        else if (padNeeded) begin
          strb.padInit = 1'b1;
          nextState    = ST_PAD;
        end else if (clearOn) begin
          strb.clrInit = 1'b1;
          nextState    = ST_CLEAR;
        end else nextState = ST_FIN;
      end
      ST_PAD: begin
        strb.wrPad = 1'b1;
        if (cntLast) begin
          if (clearOn) begin
            strb.clrInit = 1'b1;
            nextState    = ST_CLEAR;
          end else nextState = ST_FIN;
        end
      end
      ST_CLEAR: begin
        strb.wrClr = 1'b1;
        if (cntLast) nextState = ST_FIN;
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  // R2
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R2
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

// File: rtl/field_xfer.sv
module field_xfer
  import field_xfer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] src1Msl,
  input  logic [ADDR_W-1:0] src1Lsl,
  input  logic [ADDR_W-1:0] dst2Msl,
  input  logic [ADDR_W-1:0] dst2Lsl,
  input  logic              descend,
  input  logic              clearSrc,
  output logic              busy,
  output logic              done,
  output logic              rdEn,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [CHAR_W-1:0] rdData,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [CHAR_W-1:0] wrData
);

  xfer_strb_t strb;
  logic cntLast, padNeeded, clearOn;

  field_xfer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .cntLast   (cntLast),
    .padNeeded (padNeeded),
    .clearOn   (clearOn),
    .strb      (strb),
    .busy      (busy),
    .done      (done)
  );

  field_xfer_dp #(.ADDR_W(ADDR_W), .CHAR_W(CHAR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .src1MslIn (src1Msl),
    .src1LslIn (src1Lsl),
    .dst2MslIn (dst2Msl),
    .dst2LslIn (dst2Lsl),
    .descIn    (descend),
    .clearIn   (clearSrc),
    .rdData    (rdData),
    .rdAddr    (rdAddr),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .cntLast   (cntLast),
    .padNeeded (padNeeded),
    .clearOn   (clearOn)
  );

  assign rdEn = strb.rdEn;

  // R7 R8: a write not preceded by a read carries the space code
  space_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !$past(rdEn)) |-> (wrData == '0));

  // R1
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !wrEn));

endmodule

// File: tb/test_field_xfer.sv
module test_field_xfer;

  localparam int AW = 8;
  localparam int CW = 6;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] src1Msl = '0, src1Lsl = '0, dst2Msl = '0, dst2Lsl = '0;
  logic descend = 1'b0, clearSrc = 1'b0;
  logic busy, done, rdEn, wrEn;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [CW-1:0] rdData, wrData;

  logic tbWe = 1'b0;
  logic [AW-1:0] tbAddr = '0;
  logic [CW-1:0] tbData = '0;
  logic [CW-1:0] mem [MEMN];
  int refMem [MEMN];

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic rd;
    logic [AW-1:0] ra;
    logic wr;
    logic [AW-1:0] wa;
    logic [CW-1:0] wd;
    logic dn;
  } rec_t;
  rec_t expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  field_xfer #(.ADDR_W(AW), .CHAR_W(CW)) i_field_xfer (
    .clk(clk), .rstN(rstN), .start(start),
    .src1Msl(src1Msl), .src1Lsl(src1Lsl), .dst2Msl(dst2Msl), .dst2Lsl(dst2Lsl),
    .descend(descend), .clearSrc(clearSrc),
    .busy(busy), .done(done), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  // Memory with one-cycle read latency
  always @(posedge clk) begin
    if (tbWe) mem[tbAddr] <= tbData;
    else if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic poke(input int a, input int v);
    @(negedge clk);
    tbWe = 1'b1; tbAddr = AW'(a); tbData = CW'(v);
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < 64; i++) poke(i, ((i * 7 + seed) % 63) + 1);
  endtask

  // Behavioural model of the serial move on the bench's copy of memory
  task automatic build(input int m1, input int l1, input int m2, input int l2, input bit d, input bit c);
    int n1, n2, n, st, s, t;
    rec_t r;
    for (int i = 0; i < MEMN; i++) refMem[i] = int'(mem[i]);
    n1 = l1 - m1 + 1;
    n2 = l2 - m2 + 1;
    n  = (n1 < n2) ? n1 : n2;
    st = d ? 1 : -1;
    s  = d ? m1 : l1;
    t  = d ? m2 : l2;
    for (int i = 0; i < n; i++) begin
      r = '0; r.rd = 1'b1; r.ra = AW'(s);
      expQ.push_back(r); tagQ.push_back(d ? "R5" : "R4");
      r = '0; r.wr = 1'b1; r.wa = AW'(t); r.wd = CW'(refMem[s]);
      expQ.push_back(r); tagQ.push_back("R3");
      refMem[t] = refMem[s];
      s += st; t += st;
    end
    for (int i = 0; i < n2 - n; i++) begin
      r = '0; r.wr = 1'b1; r.wa = AW'(t);
      expQ.push_back(r); tagQ.push_back(d ? "R8" : "R7");
      refMem[t] = 0;
      t += st;
    end
    if (c) begin
      s = d ? m1 : l1;
      for (int i = 0; i < n1; i++) begin
        r = '0;
        if (!(s >= m2 && s <= l2)) begin
          r.wr = 1'b1; r.wa = AW'(s);
          refMem[s] = 0;
        end
        expQ.push_back(r); tagQ.push_back("R9");
        s += st;
      end
    end
    r = '0; r.dn = 1'b1;
    expQ.push_back(r); tagQ.push_back("R2");
  endtask

  task automatic runXfer(input int m1, input int l1, input int m2, input int l2,
                         input bit d, input bit c, input string finTag, input int disturbAt);
    rec_t r;
    string tg;
    int idx;
    int bad;
    build(m1, l1, m2, l2, d, c);
    @(negedge clk);
    src1Msl = AW'(m1); src1Lsl = AW'(l1); dst2Msl = AW'(m2); dst2Lsl = AW'(l2);
    descend = d; clearSrc = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0;
    while (expQ.size() > 0) begin
      r  = expQ.pop_front();
      tg = tagQ.pop_front();
      check(busy == 1'b1, "R2", "busy during move", int'(busy), 1);
      check(rdEn == r.rd, tg, "rdEn", int'(rdEn), int'(r.rd));
      if (r.rd) check(rdAddr == r.ra, tg, "rdAddr", int'(rdAddr), int'(r.ra));
      check(wrEn == r.wr, tg, "wrEn", int'(wrEn), int'(r.wr));
      if (r.wr) begin
        check(wrAddr == r.wa, tg, "wrAddr", int'(wrAddr), int'(r.wa));
        check(wrData == r.wd, tg, "wrData", int'(wrData), int'(r.wd));
      end
      check(done == r.dn, tg, "done", int'(done), int'(r.dn));
      if (idx == disturbAt) begin
        // R11: new start and ranges while busy
        start = 1'b1; src1Msl = 8'd200; src1Lsl = 8'd210; dst2Msl = 8'd100; dst2Lsl = 8'd101;
        descend = ~d; clearSrc = ~c;
      end else start = 1'b0;
      idx++;
      @(negedge clk);
    end
    start = 1'b0;
    check(!busy && !done, "R2", "idle after done", int'({busy, done}), 0);
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (int'(mem[i]) != refMem[i]) bad++;
    check(bad == 0, finTag, "final memory mismatches", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rdEn && !wrEn, "R1", "outputs in reset", int'({busy, done, rdEn, wrEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rdEn && !wrEn, "R1", "outputs after reset", int'({busy, done, rdEn, wrEn}), 0);

    fillMem(3);
    runXfer(10, 14, 30, 34, 1'b0, 1'b0, "R4", -1);
    runXfer(10, 12, 40, 46, 1'b0, 1'b0, "R7", -1);
    runXfer(10, 12, 40, 46, 1'b1, 1'b0, "R8", -1);
    runXfer(10, 17, 50, 52, 1'b0, 1'b0, "R6", -1);
    runXfer(10, 17, 50, 52, 1'b1, 1'b0, "R6", -1);
    fillMem(11);
    runXfer(10, 13, 20, 25, 1'b0, 1'b1, "R9", 3);
    runXfer(4, 9, 7, 12, 1'b0, 1'b1, "R10", -1);
    runXfer(9, 16, 5, 12, 1'b1, 1'b1, "R10", 5);
    runXfer(30, 30, 33, 33, 1'b1, 1'b1, "R9", -1);
    runXfer(30, 30, 33, 35, 1'b0, 1'b1, "R7", -1);
    runXfer(40, 45, 40, 45, 1'b1, 1'b1, "R9", -1);

    // R10: hand-computed overlap results
    poke(10, 1); poke(11, 2); poke(12, 3);
    runXfer(10, 12, 11, 13, 1'b0, 1'b0, "R10", -1);
    check(mem[11] == 1 && mem[12] == 2 && mem[13] == 3, "R10", "ascending shift right",
          int'({mem[11], mem[12], mem[13]}), int'({6'd1, 6'd2, 6'd3}));
    poke(10, 1); poke(11, 2); poke(12, 3); poke(13, 4);
    runXfer(10, 12, 11, 13, 1'b1, 1'b0, "R10", -1);
    check(mem[11] == 1 && mem[12] == 1 && mem[13] == 1, "R10", "descending smear",
          int'({mem[11], mem[12], mem[13]}), int'({6'd1, 6'd1, 6'd1}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule